// File: doc/BRIEF.md
# Eight-Channel DAC Input Router

This block takes serial audio for eight DAC channels, grouped as four stereo pairs, and turns it into eight parallel signed samples. Every sample is scaled by its own 10-bit linear volume code. All channels share one bit clock and one frame clock. The block runs directly on the bit clock.

Data arrives in one of two layouts, chosen by `packed_mode`:

- **Per-pair mode:** each stereo pair has its own data line.
- **Packed mode:** all eight channels are time-multiplexed onto data line 0 in 32-bit slots.

A replicate switch copies the first pair's left and right samples to every pair. Each channel still applies its own volume code to the copied sample.

Samples are two's complement words of 16, 20 or 24 bits, sign-extended to 24 bits at the output. Once a frame is complete, all eight outputs update together and `out_valid` pulses for one bit-clock cycle.

Top module: `dac_input_router`

## Requirements
- R1: After reset is released, `out_valid` is 0 and all of `ch_data` is 0 until the first completed frame.
- R2: In per-pair mode, pair p (channels 2p and 2p+1) is read only from `sdata[p]`. The left word (channel 2p) is read while `lrclk` is low and the right word (channel 2p+1) while it is high. Each word is MSB first, and its first bit is sampled on the second rising `bclk` edge after the `lrclk` transition.
- R3: In packed mode, only `sdata[0]` is read and `sdata[3:1]` has no effect. A frame starts at a falling `lrclk` edge. The MSB of slot 0 is sampled on the next rising `bclk` edge. Slot s (channel s, 0..7) begins 32·s bit clocks after that edge.
- R4: The word width is set by `wsel`: 0 gives 16 bits, 1 gives 20 bits, 2 and 3 give 24 bits. Only the first W bits of a word or slot are used, and the sample is sign-extended to 24 bits.
- R5: Channel i uses code c = `atten_codes[10i+9:10i]`. Its output is sample·(c+1)/1024, rounded toward zero, and placed on `ch_data[24i+23:24i]`.
- R6: Code 1023 passes the sample through unchanged, including positive and negative full scale.
- R7: With `replicate` set, channels 2k and 2k+1 carry pair 0's left and right samples, each scaled by its own code. Data on the other lines (per-pair mode) or slots 2..7 (packed mode) has no effect.
- R8: A frame ends at a falling `lrclk` edge, except the first falling edge after reset. In the cycle after that edge is sampled, `out_valid` is high for exactly one `bclk` cycle and `ch_data` holds the new frame. At all other times `ch_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock, which is also the block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrclk | input | 1 | Frame clock: low for left, high for right; its falling edge marks a frame boundary |
| sdata | input | 4 | Serial data, one line per stereo pair; line 0 carries the packed stream |
| packed_mode | input | 1 | 1 = all channels on line 0 in 32-bit slots |
| replicate | input | 1 | 1 = copy pair 0 to every pair |
| wsel | input | 2 | Word width: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| atten_codes | input | 80 | Eight 10-bit volume codes, channel i at bits 10i+9:10i |
| ch_data | output | 192 | Eight signed 24-bit samples, channel i at bits 24i+23:24i |
| out_valid | output | 1 | One-cycle strobe when `ch_data` is updated |

## Verification
The hardest case to reach from the ports is a packed frame whose last slot holds a word that must land in channel 7. Reaching it takes a full 256-clock serial stream, with line 0 carrying the slot bits and the idle lines toggling the whole time to show they are ignored. The bench builds every frame bit by bit from per-channel integers, so any slot offset or width selection can be reached.

Rounding toward zero on negative products is reached through small negative samples with small codes. For example, −1500 with code 0 must give −1, not −2.

Replication is checked with distinct values on every line and slot, so a copy taken from the wrong source shows up as a miscompare.

// File: rtl/dac_router_pkg.sv
// Shared definitions for the DAC input router: word-width encoding and
// its decode to a bit count. Assumes output samples are at least 24 bits.
package dac_router_pkg;

    typedef enum logic [1:0] {
        WSEL_16  = 2'd0,
        WSEL_20  = 2'd1,
        WSEL_24  = 2'd2,
        WSEL_24B = 2'd3
    } wsel_e;

    // Number of significant bits carried per word for a width select code
    function automatic int word_bits(input logic [1:0] sel);
        case (wsel_e'(sel))
            WSEL_16: return 16;
            WSEL_20: return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/dac_router_timing.sv
// Frame timing for the router. Samples the frame clock on each bit clock,
// restarts a bit counter at each half-frame (per-pair mode) or at each
// falling edge (packed mode), and flags frame completion on falling edges
// after the first. Assumes the frame clock changes away from the bclk
// rising edge.
module dac_router_timing #(
    parameter int N_CH      = 8,
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = $clog2(N_CH * SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrclk,
    input  logic             packed_mode,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             cap_en,
    output logic             half,
    output logic             frame_done
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N_CH * SLOT_BITS - 1);

    logic lr_q;
    logic active;
    logic started;
    logic fall;
    logic restart;

    assign fall       = lr_q & ~lrclk;
    assign restart    = packed_mode ? fall : (lr_q ^ lrclk);
    assign cap_en     = active & ~restart;
    assign frame_done = fall & started;

    // Remember the previous frame clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lr_q <= 1'b0;
        else        lr_q <= lrclk;
    end

    // Bit position counter, restarted at each word or frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            active  <= 1'b0;
            half    <= 1'b0;
        end else if (restart) begin
            bit_cnt <= '0;
            active  <= 1'b1;
            half    <= lrclk;
        end else if (active && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // The first falling edge only opens a frame; later ones close one
    always_ff @(posedge clk) begin
        if (!rst_n)    started <= 1'b0;
        else if (fall) started <= 1'b1;
    end

endmodule

// File: rtl/dac_router_capture.sv
// Per-channel serial deserializers. Each channel shifts in MSB-first bits
// from its own line and half (per-pair mode) or from its slot on line 0
// (packed mode), then sign-extends the selected word width. Assumes the
// word length never exceeds SAMPLE_W.
module dac_router_capture #(
    parameter int N_PAIRS   = 4,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = $clog2(2 * N_PAIRS * SLOT_BITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_PAIRS-1:0]            sdata,
    input  logic                          packed_mode,
    input  logic                          cap_en,
    input  logic                          half,
    input  logic [CNT_W-1:0]              bit_cnt,
    input  logic [CNT_W-1:0]              wlen,
    output logic [2*N_PAIRS*SAMPLE_W-1:0] raw_flat
);
    localparam int N_CH    = 2 * N_PAIRS;
    localparam int SLOT_LG = $clog2(SLOT_BITS);
    localparam int SEL_W   = CNT_W - SLOT_LG;

    logic [CNT_W-1:0] sft;
    logic [CNT_W-1:0] slot_pos;

    assign sft      = CNT_W'(SAMPLE_W) - wlen;
    assign slot_pos = CNT_W'(bit_cnt[SLOT_LG-1:0]);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int   LANE = ch / 2;
        localparam logic SIDE = (ch % 2) == 1;

        logic [SAMPLE_W-1:0] sh;
        logic                take;
        logic                din;

        // Decide whether this bit belongs to this channel, and from which line
        always_comb begin
            if (packed_mode) begin
                take = cap_en && (bit_cnt[CNT_W-1:SLOT_LG] == SEL_W'(ch))
                              && (slot_pos < wlen);
                din  = sdata[0];
            end else begin
                take = cap_en && (half == SIDE) && (bit_cnt < wlen);
                din  = sdata[LANE];
            end
        end

        // Shift register for the channel's word
        always_ff @(posedge clk) begin
            if (!rst_n)    sh <= '0;
            else if (take) sh <= {sh[SAMPLE_W-2:0], din};
        end

        // Sign-extend the low wlen bits to the full sample width
        always_comb begin
            raw_flat[ch*SAMPLE_W +: SAMPLE_W] = $signed(sh << sft) >>> sft;
        end
    end

endmodule

// File: rtl/dac_router_atten.sv
// Linear attenuator: out = sample * (code + 1) / 2^CODE_W, rounded toward
// zero. Purely combinational. Assumes the full-scale product fits in
// SAMPLE_W + CODE_W + 2 bits.
module dac_router_atten #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 10
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [CODE_W-1:0]   code,
    output logic signed [SAMPLE_W-1:0] scaled
);
    localparam int PROD_W = SAMPLE_W + CODE_W + 2;
    localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((1 << CODE_W) - 1);

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;

    // Multiply, then bias negative products so the shift truncates toward zero
    always_comb begin
        s_ext  = PROD_W'(sample);
        gain   = $signed(PROD_W'(code)) + PROD_W'(1);
        prod   = s_ext * gain;
        biased = prod[PROD_W-1] ? (prod + BIAS) : prod;
        scaled = SAMPLE_W'(biased >>> CODE_W);
    end

endmodule

// File: rtl/dac_input_router.sv
// Top of the DAC input router. Deserializes four per-pair lines or one
// packed line, optionally copies pair 0 to every pair, scales each
// channel by its own code, and registers all outputs together at the end
// of a frame. Runs on the bit clock. Assumes the mode, width and
// replicate selects are changed only between frames.
module dac_input_router #(
    parameter int N_PAIRS   = 4,
    parameter int SAMPLE_W  = 24,
    parameter int CODE_W    = 10,
    parameter int SLOT_BITS = 32
) (
    input  logic                          bclk,
    input  logic                          rst_n,
    input  logic                          lrclk,
    input  logic [N_PAIRS-1:0]            sdata,
    input  logic                          packed_mode,
    input  logic                          replicate,
    input  logic [1:0]                    wsel,
    input  logic [2*N_PAIRS*CODE_W-1:0]   atten_codes,
    output logic [2*N_PAIRS*SAMPLE_W-1:0] ch_data,
    output logic                          out_valid
);
    import dac_router_pkg::*;

    localparam int N_CH  = 2 * N_PAIRS;
    localparam int CNT_W = $clog2(N_CH * SLOT_BITS);

    logic [CNT_W-1:0]           bit_cnt;
    logic [CNT_W-1:0]           wlen;
    logic                       cap_en;
    logic                       half;
    logic                       frame_done;
    logic [N_CH*SAMPLE_W-1:0]   raw_flat;
    logic [N_CH*SAMPLE_W-1:0]   sel_flat;
    logic [N_CH*SAMPLE_W-1:0]   att_flat;

    assign wlen = CNT_W'(word_bits(wsel));

    dac_router_timing #(
        .N_CH(N_CH), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)
    ) u_timing (
        .clk(bclk), .rst_n(rst_n), .lrclk(lrclk), .packed_mode(packed_mode),
        .bit_cnt(bit_cnt), .cap_en(cap_en), .half(half), .frame_done(frame_done)
    );

    dac_router_capture #(
        .N_PAIRS(N_PAIRS), .SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)
    ) u_capture (
        .clk(bclk), .rst_n(rst_n), .sdata(sdata), .packed_mode(packed_mode),
        .cap_en(cap_en), .half(half), .bit_cnt(bit_cnt), .wlen(wlen),
        .raw_flat(raw_flat)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_route
        localparam int SRC = ch % 2;

        // Pick own capture or pair 0 copy
        assign sel_flat[ch*SAMPLE_W +: SAMPLE_W] = replicate
            ? raw_flat[SRC*SAMPLE_W +: SAMPLE_W]
            : raw_flat[ch*SAMPLE_W +: SAMPLE_W];

        dac_router_atten #(
            .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)
        ) u_atten (
            .sample(sel_flat[ch*SAMPLE_W +: SAMPLE_W]),
            .code(atten_codes[ch*CODE_W +: CODE_W]),
            .scaled(att_flat[ch*SAMPLE_W +: SAMPLE_W])
        );
    end

    // Register all channels together with a one-cycle strobe
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            ch_data   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= frame_done;
            if (frame_done) ch_data <= att_flat;
        end
    end

endmodule

// File: rtl/dac_router_checker.sv
// Property checker for the DAC input router, bound to the top module.
// Observes the ports and the boundary between routing and attenuation.
module dac_router_checker #(
    parameter int N_CH     = 8,
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lrclk,
    input logic                       out_valid,
    input logic [N_CH*SAMPLE_W-1:0]   ch_data,
    input logic [N_CH*SAMPLE_W-1:0]   sel_flat,
    input logic [N_CH*SAMPLE_W-1:0]   att_flat,
    input logic [N_CH*CODE_W-1:0]     atten_codes
);
    // R1: outputs are cleared on the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && ch_data == '0));

    // R8: strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: outputs change only with the strobe
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (ch_data == $past(ch_data)));

    // R8: strobe follows a high-to-low frame clock transition
    a_r8_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!$past(lrclk) && $past(lrclk, 2)));

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
        logic signed [SAMPLE_W-1:0] s_in;
        logic signed [SAMPLE_W-1:0] s_out;
        logic        [CODE_W-1:0]   c;

        assign s_in  = sel_flat[ch*SAMPLE_W +: SAMPLE_W];
        assign s_out = att_flat[ch*SAMPLE_W +: SAMPLE_W];
        assign c     = atten_codes[ch*CODE_W +: CODE_W];

        // R6: full-scale code is unity gain
        a_r6_unity_gain: assert property (@(posedge clk) disable iff (!rst_n)
            (&c) |-> (s_out == s_in));

        // R5: non-negative input never grows nor flips sign
        a_r5_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (s_in >= 0) |-> (s_out >= 0 && s_out <= s_in));

        // R5: negative input never grows in magnitude nor flips sign
        a_r5_neg_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (s_in < 0) |-> (s_out <= 0 && s_out >= s_in));
    end

endmodule

bind dac_input_router dac_router_checker #(
    .N_CH(2 * N_PAIRS), .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)
) u_chk (
    .clk(bclk), .rst_n(rst_n), .lrclk(lrclk), .out_valid(out_valid),
    .ch_data(ch_data), .sel_flat(sel_flat), .att_flat(att_flat),
    .atten_codes(atten_codes)
);

// File: tb/sim_dac_input_router.sv
// Directed bench for the DAC input router: one task per scenario.
module sim_dac_input_router;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NC = 8;
    localparam int SW = 24;
    localparam int CW = 10;

    logic              bclk = 1'b0;
    logic              rst_n;
    logic              lrclk;
    logic [NP-1:0]     sdata;
    logic              packed_mode;
    logic              replicate;
    logic [1:0]        wsel;
    logic [NC*CW-1:0]  atten_codes;
    logic [NC*SW-1:0]  ch_data;
    logic              out_valid;

    int n_chk = 0;
    int n_bad = 0;
    int tx[NC];
    int codes[NC];
    bit finished = 0;

    always #(CLK_PERIOD/2) bclk = ~bclk;

    dac_input_router u0 (
        .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
        .packed_mode(packed_mode), .replicate(replicate), .wsel(wsel),
        .atten_codes(atten_codes), .ch_data(ch_data), .out_valid(out_valid)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] s);
        case (s)
            2'd0:    return 16;
            2'd1:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int scaled(input int s, input int c);
        longint p;
        p = longint'(s) * longint'(c + 1);
        return int'(p / 1024);
    endfunction

    task automatic set_codes(input int c0, input int c1, input int c2, input int c3,
                             input int c4, input int c5, input int c6, input int c7);
        codes = '{c0, c1, c2, c3, c4, c5, c6, c7};
        for (int i = 0; i < NC; i++) atten_codes[i*CW +: CW] = CW'(codes[i]);
    endtask

    task automatic set_tx(input int v0, input int v1, input int v2, input int v3,
                          input int v4, input int v5, input int v6, input int v7);
        tx = '{v0, v1, v2, v3, v4, v5, v6, v7};
    endtask

    function automatic int out_of(input int ch);
        return int'($signed(ch_data[ch*SW +: SW]));
    endfunction

    // Called one negedge after the closing falling edge
    task automatic check_outputs(input string req, input bit rep);
        int held;
        check(req, "valid at frame end", out_valid, 1);
        for (int ch = 0; ch < NC; ch++) begin
            int src;
            src = rep ? tx[ch % 2] : tx[ch];
            check(req, $sformatf("ch%0d", ch), out_of(ch), scaled(src, codes[ch]));
        end
        held = out_of(NC - 1);
        @(negedge bclk);
        check("R8", "valid pulse width", out_valid, 0);
        check("R8", "data held after pulse", out_of(NC - 1), held);
    endtask

    task automatic send_normal(input string req, input bit rep);
        int w;
        w = width_of(wsel);
        packed_mode = 1'b0;
        replicate   = rep;
        @(negedge bclk); lrclk = 1'b1; sdata = '0;
        @(negedge bclk); lrclk = 1'b0;
        for (int k = 1; k < 32; k++) begin
            @(negedge bclk);
            for (int p = 0; p < NP; p++) sdata[p] = (k <= w) ? tx[2*p][w-k] : 1'b0;
            if (k == 12) check("R8", "no valid mid-frame", out_valid, 0);
        end
        @(negedge bclk); lrclk = 1'b1; sdata = '0;
        for (int k = 1; k < 32; k++) begin
            @(negedge bclk);
            for (int p = 0; p < NP; p++) sdata[p] = (k <= w) ? tx[2*p+1][w-k] : 1'b0;
        end
        @(negedge bclk); lrclk = 1'b0; sdata = '0;
        @(negedge bclk);
        check_outputs(req, rep);
    endtask

    task automatic send_packed(input string req, input bit rep);
        int w;
        w = width_of(wsel);
        packed_mode = 1'b1;
        replicate   = rep;
        @(negedge bclk); lrclk = 1'b1; sdata = '0;
        @(negedge bclk); lrclk = 1'b0;
        for (int p = 0; p < 256; p++) begin
            int b;
            b = p % 32;
            @(negedge bclk);
            sdata[0]   = (b < w) ? tx[p/32][w-1-b] : 1'b0;
            sdata[3:1] = 3'(p * 5 + 3);
        end
        @(negedge bclk); lrclk = 1'b1; sdata = '0;
        @(negedge bclk); lrclk = 1'b0;
        @(negedge bclk);
        check_outputs(req, rep);
    endtask

    task automatic t_reset;
        check("R1", "valid after reset", out_valid, 0);
        for (int ch = 0; ch < NC; ch++) check("R1", $sformatf("ch%0d zero", ch), out_of(ch), 0);
    endtask

    task automatic t_normal_unity;
        wsel = 2'd2;
        set_codes(1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023);
        set_tx(8388607, -8388608, 123456, -1, 0, 1, 5929050, -654321);
        send_normal("R2_R6", 1'b0);
    endtask

    task automatic t_normal_w16;
        wsel = 2'd0;
        set_tx(32767, -32768, -2, 1000, -12345, 7, 0, 20000);
        send_normal("R4_w16", 1'b0);
    endtask

    task automatic t_normal_w20;
        wsel = 2'd1;
        set_tx(524287, -524288, -3, 99999, -250000, 1, -1, 300000);
        send_normal("R4_w20", 1'b0);
    endtask

    task automatic t_atten;
        wsel = 2'd2;
        set_codes(0, 511, 1, 700, 1022, 0, 255, 1023);
        set_tx(-1500, -1, 1023, -8388608, 8388607, 1500, -777, -4);
        send_normal("R5", 1'b0);
    endtask

    task automatic t_packed_24;
        wsel = 2'd3;
        set_codes(1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023);
        set_tx(-8388608, 8388607, 4660, -4660, 1, -1, 7340032, -3);
        send_packed("R3", 1'b0);
    endtask

    task automatic t_packed_16;
        wsel = 2'd0;
        set_codes(512, 1023, 0, 100, 1023, 900, 3, 1023);
        set_tx(-32768, 32767, 5000, -5000, 12, -30000, -1024, 255);
        send_packed("R3_R4", 1'b0);
    endtask

    task automatic t_replicate_normal;
        wsel = 2'd2;
        set_codes(1023, 1023, 511, 255, 0, 767, 1023, 100);
        set_tx(400000, -300000, 11, 22, 33, 44, 55, 66);
        send_normal("R7", 1'b1);
    endtask

    task automatic t_replicate_packed;
        wsel = 2'd1;
        set_codes(300, 1023, 1023, 300, 10, 20, 1023, 1023);
        set_tx(-200000, 150000, 9, 8, 7, 6, 5, 4);
        send_packed("R7", 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; lrclk = 1'b0; sdata = '0;
        packed_mode = 1'b0; replicate = 1'b0; wsel = 2'd2;
        atten_codes = '1;
        repeat (4) @(negedge bclk);
        rst_n = 1'b1;
        @(negedge bclk);
        t_reset();
        t_normal_unity();
        t_normal_w16();
        t_normal_w20();
        t_atten();
        t_packed_24();
        t_packed_16();
        t_replicate_normal();
        t_replicate_packed();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule